// File: doc/BRIEF.md
# Counter Compare Channel

This block is one compare channel hung off a shared free-running 16-bit counter. Software loads a 16-bit compare value as two bytes plus a mode byte over a small byte-wide register bus. On each new counter value that equals the compare value, while comparison is enabled, the channel fires one match event. The mode bits choose what that event does. It can set a sticky flag and request an interrupt, as a software timer. It can invert a dedicated output pin, as a high-speed output. In the watchdog build it can emit a one-clock reset pulse.

The compare value can be updated without a spurious match. Writing the low compare byte switches comparison off, and writing the high byte switches it back on. Software therefore writes the low byte first and the high byte second. The enable bit can still be written directly through the mode byte. The count-enable strobe tells the channel that the counter is about to advance. This lets a stalled counter that sits on the compare value produce only one event.

Top module: `cnt_cmp_channel`

## Requirements
- R1: A match event happens only while the compare-enable bit (mode bit 6) is 1 and the counter input equals {high byte, low byte} of the compare register.
- R2: A write to address 1 (low compare byte) clears the compare-enable bit. A write to address 2 (high compare byte) sets it. Both take effect at the next clock edge.
- R3: Address 0 holds the mode byte: bit 6 compare-enable, bit 5 and bit 4 capture selects (stored only), bit 3 match, bit 2 toggle, bit 1 PWM select (stored only), bit 0 interrupt-enable. Bit 7 always reads 0. Writing bit 6 here sets or clears comparison directly, and read-back shows the automatic changes made by R2.
- R4: A match event with the match bit set raises the flag (read at address 3, bit 0) one clock later. `irq_o` equals the flag AND the interrupt-enable bit.
- R5: The flag holds until a write to address 3 with bit 0 = 0. A write with bit 0 = 1 leaves the flag unchanged. A match in the same cycle wins over a clear.
- R6: With compare-enable, match and toggle all set, `out_pin_o` inverts one clock after every match event.
- R7: In the watchdog build (`IS_WDOG` = 1), a match event while `wdog_en_i` is 1 makes `wdog_rst_o` high for exactly one clock, one clock later. The match bit is not needed for this.
- R8: A counter value gives at most one match event. After an event, no further event occurs until a cycle with `cnt_tick_i` high has passed, even if the counter input stays equal and comparison is re-enabled.
- R9: After reset, the mode and compare registers and the flag are 0, `out_pin_o` is 1, and `irq_o` and `wdog_rst_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_i | input | 16 | Current value of the shared counter |
| cnt_tick_i | input | 1 | Counter advances at the end of this cycle |
| wdog_en_i | input | 1 | Global watchdog enable from the shared mode control |
| reg_addr_i | input | 2 | Register address: 0 mode, 1 compare low, 2 compare high, 3 flag |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Interrupt request |
| out_pin_o | output | 1 | High-speed output pin |
| wdog_rst_o | output | 1 | Watchdog reset pulse |

## Verification
The bench sweeps the counter across a window around many compare values. These include the wrap points 0x0000, 0x00FF/0x0100 and 0xFFFF, and the sweeps run under every combination of the match, toggle, interrupt-enable and watchdog-enable controls. A comparator that misses a byte boundary or fires early would set the flag on the wrong step. A counter that stalls on the compare value while the flag is cleared exposes a level-based detector, which would set the flag again and again or toggle the pin each cycle. Other checks target the register side effects. If the low-byte write failed to disable comparison, a match would fire while the compare value is half updated. If a write of 1 cleared the flag, a pending interrupt would be lost.

// File: rtl/cnt_cmp_channel_pkg.sv
package cnt_cmp_channel_pkg;

    typedef enum logic [1:0] {
        ADDR_MODE = 2'd0,
        ADDR_CMPL = 2'd1,
        ADDR_CMPH = 2'd2,
        ADDR_FLAG = 2'd3
    } reg_addr_e;

    // Packed so that ecom lands on bit 6 and ie on bit 0 of the mode byte.
    typedef struct packed {
        logic ecom;
        logic capp;
        logic capn;
        logic mat;
        logic tog;
        logic pwm;
        logic ie;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

endpackage

// File: rtl/cnt_cmp_regs.sv
module cnt_cmp_regs
    import cnt_cmp_channel_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CMP_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [1:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              flag_i,
    output logic [CMP_W-1:0]  cmp_o,
    output mode_t             mode_o,
    output logic [DATA_W-1:0] rdata_o
);

    typedef struct packed {
        logic [DATA_W-1:0] hi;
        logic [DATA_W-1:0] lo;
        mode_t             mode;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            case (reg_addr_e'(addr_i))
                ADDR_MODE: st_d.mode = mode_t'(wdata_i[MODE_W-1:0]);
                ADDR_CMPL: begin
                    st_d.lo        = wdata_i;
                    st_d.mode.ecom = 1'b0;
                end
                ADDR_CMPH: begin
                    st_d.hi        = wdata_i;
                    st_d.mode.ecom = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (reg_addr_e'(addr_i))
            ADDR_MODE: rdata_o = DATA_W'(st_q.mode);
            ADDR_CMPL: rdata_o = st_q.lo;
            ADDR_CMPH: rdata_o = st_q.hi;
            default:   rdata_o = DATA_W'(flag_i);
        endcase
    end

    assign cmp_o  = {st_q.hi, st_q.lo};
    assign mode_o = st_q.mode;

    assert_lo_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == ADDR_CMPL) |=> !mode_o.ecom);
    assert_hi_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == ADDR_CMPH) |=> mode_o.ecom);
    assert_cmp_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(cmp_o));

endmodule

// File: rtl/cnt_cmp_match.sv
module cnt_cmp_match #(
    parameter int CMP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CMP_W-1:0] cnt_i,
    input  logic             tick_i,
    input  logic [CMP_W-1:0] cmp_i,
    input  logic             en_i,
    output logic             fire_o
);

    typedef struct packed {
        logic armed;
    } state_t;

    state_t st_d, st_q;
    logic   equal;

    assign equal  = (cnt_i == cmp_i);
    assign fire_o = en_i && equal && st_q.armed;

    always_comb begin
        st_d = st_q;
        if (tick_i)      st_d.armed = 1'b1;  // counter moves on: next value may fire
        else if (fire_o) st_d.armed = 1'b0;  // this value is used up
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{armed: 1'b1};
        else        st_q <= st_d;
    end

    assert_single_fire_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_o && !tick_i) |=> !fire_o);

endmodule

// File: rtl/cnt_cmp_actions.sv
module cnt_cmp_actions #(
    parameter int IS_WDOG = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    input  logic ecom_i,
    input  logic mat_i,
    input  logic tog_i,
    input  logic ie_i,
    input  logic wdog_en_i,
    input  logic flag_clr_i,
    output logic flag_o,
    output logic irq_o,
    output logic pin_o,
    output logic wdog_rst_o
);

    localparam logic WD_ON = (IS_WDOG != 0);

    typedef struct packed {
        logic flag;
        logic pin;
        logic rst;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fire_i && mat_i)     st_d.flag = 1'b1;
        else if (flag_clr_i)     st_d.flag = 1'b0;
        if (fire_i && ecom_i && mat_i && tog_i)
            st_d.pin = ~st_q.pin;
        st_d.rst = WD_ON && fire_i && wdog_en_i && !st_q.rst;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{flag: 1'b0, pin: 1'b1, rst: 1'b0};
        else        st_q <= st_d;
    end

    assign flag_o     = st_q.flag;
    assign irq_o      = st_q.flag && ie_i;
    assign pin_o      = st_q.pin;
    assign wdog_rst_o = st_q.rst;

    assert_flag_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(fire_i && mat_i));
    assert_flag_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !flag_clr_i) |=> flag_o);
    assert_pin_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && ecom_i && mat_i && tog_i) |=> (pin_o != $past(pin_o)));
    assert_rst_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst_o |=> !wdog_rst_o);

endmodule

// File: rtl/cnt_cmp_channel.sv
module cnt_cmp_channel
    import cnt_cmp_channel_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int IS_WDOG = 1,
    localparam int CMP_W  = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CMP_W-1:0]  cnt_i,
    input  logic              cnt_tick_i,
    input  logic              wdog_en_i,
    input  logic [1:0]        reg_addr_i,
    input  logic              reg_wr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o,
    output logic              out_pin_o,
    output logic              wdog_rst_o
);

    logic [CMP_W-1:0] cmp;
    mode_t            mode;
    logic             fire;
    logic             flag;
    logic             flag_clr;

    assign flag_clr = reg_wr_i && (reg_addr_i == ADDR_FLAG) && !reg_wdata_i[0];

    cnt_cmp_regs #(.DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .flag_i  (flag),
        .cmp_o   (cmp),
        .mode_o  (mode),
        .rdata_o (reg_rdata_o)
    );

    cnt_cmp_match #(.CMP_W(CMP_W)) u_match (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_i  (cnt_i),
        .tick_i (cnt_tick_i),
        .cmp_i  (cmp),
        .en_i   (mode.ecom),
        .fire_o (fire)
    );

    cnt_cmp_actions #(.IS_WDOG(IS_WDOG)) u_actions (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire_i     (fire),
        .ecom_i     (mode.ecom),
        .mat_i      (mode.mat),
        .tog_i      (mode.tog),
        .ie_i       (mode.ie),
        .wdog_en_i  (wdog_en_i),
        .flag_clr_i (flag_clr),
        .flag_o     (flag),
        .irq_o      (irq_o),
        .pin_o      (out_pin_o),
        .wdog_rst_o (wdog_rst_o)
    );

    assert_no_match_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !mode.ecom |=> $stable(out_pin_o) || $past(mode.ecom));
    assert_fire_needs_equal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (cnt_i == cmp));

endmodule

// File: tb/cnt_cmp_channel_tb.sv
module cnt_cmp_channel_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cnt;
    logic        tick;
    logic        wdog_en;
    logic [1:0]  addr;
    logic        wr;
    logic [7:0]  wdata;
    logic [7:0]  rdata;
    logic        irq, pin, wrst;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    cnt_cmp_channel u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_i       (cnt),
        .cnt_tick_i  (tick),
        .wdog_en_i   (wdog_en),
        .reg_addr_i  (addr),
        .reg_wr_i    (wr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq),
        .out_pin_o   (pin),
        .wdog_rst_o  (wrst)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic wreg(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        cyc();
        wr = 1'b0;
    endtask

    task automatic rreg(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    logic [7:0]  rv;
    logic        exp_pin;
    logic [15:0] cmps [8] = '{16'h0000, 16'h0001, 16'h00FF, 16'h0100,
                              16'h1234, 16'h7FFF, 16'hFFFE, 16'hFFFF};

    initial begin
        #(20 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cnt = 16'h5555; tick = 1'b0; wdog_en = 1'b0;
        addr = 2'd0; wr = 1'b0; wdata = 8'h00;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();

        // R9: reset state
        rreg(2'd0, rv); chk("R9 mode", 16'(rv), 16'h00);
        rreg(2'd1, rv); chk("R9 cmp low", 16'(rv), 16'h00);
        rreg(2'd2, rv); chk("R9 cmp high", 16'(rv), 16'h00);
        rreg(2'd3, rv); chk("R9 flag", 16'(rv), 16'h00);
        chk("R9 pin", 16'(pin), 16'h1);
        chk("R9 irq", 16'(irq), 16'h0);
        chk("R9 wdog", 16'(wrst), 16'h0);
        exp_pin = 1'b1;

        // R3: bit 7 reads 0, bit 6 written directly
        wreg(2'd0, 8'hFF); rreg(2'd0, rv); chk("R3 mode all", 16'(rv), 16'h7F);
        wreg(2'd0, 8'h3F); rreg(2'd0, rv); chk("R3 ecom off direct", 16'(rv), 16'h3F);
        // R2: low write clears, high write sets
        wreg(2'd0, 8'h48); wreg(2'd1, 8'h21);
        rreg(2'd0, rv); chk("R2 low clears ecom", 16'(rv), 16'h08);
        wreg(2'd2, 8'h43);
        rreg(2'd0, rv); chk("R2 high sets ecom", 16'(rv), 16'h48);
        rreg(2'd1, rv); chk("R3 cmp low rb", 16'(rv), 16'h21);
        rreg(2'd2, rv); chk("R3 cmp high rb", 16'(rv), 16'h43);

        // R1: enable off after low-byte write -> no match
        wreg(2'd1, 8'h21);
        cnt = 16'h4321; tick = 1'b1; cyc();
        cnt = 16'h4322; cyc();
        rreg(2'd3, rv); chk("R1 no flag while disabled", 16'(rv), 16'h0);
        // R3: enable directly via mode byte, then match fires
        wreg(2'd0, 8'h48);
        cnt = 16'h4321; cyc();
        rreg(2'd3, rv); chk("R3 direct enable fires", 16'(rv), 16'h1);
        cnt = 16'h4322; cyc();
        // R5: write 1 no effect, write 0 clears
        wreg(2'd3, 8'hFF); rreg(2'd3, rv); chk("R5 write 1 ignored", 16'(rv), 16'h1);
        wreg(2'd3, 8'hFE); rreg(2'd3, rv); chk("R5 write 0 clears", 16'(rv), 16'h0);
        // R4: match bit clear -> no flag
        wreg(2'd0, 8'h44);
        cnt = 16'h4321; cyc();
        cnt = 16'h4322; cyc();
        rreg(2'd3, rv); chk("R4 no flag without match bit", 16'(rv), 16'h0);

        // Sweeps: R1 R4 R6 R7 over compare values and mode combos
        for (int ci = 0; ci < 8; ci++) begin
            for (int m = 0; m < 16; m++) begin
                logic mat, tog, ie, we;
                logic [7:0] mb;
                mat = m[0]; tog = m[1]; ie = m[2]; we = m[3];
                mb  = {4'b0, mat, tog, 1'b0, ie};
                tick = 1'b1;
                cnt = cmps[ci] ^ 16'h8000;
                wdog_en = we;
                wreg(2'd0, mb);
                wreg(2'd1, cmps[ci][7:0]);
                wreg(2'd2, cmps[ci][15:8]);
                wreg(2'd3, 8'h00);
                rreg(2'd0, rv); chk("R2 mode after program", 16'(rv), 16'(mb | 8'h40));
                for (int k = -3; k <= 3; k++) begin
                    cnt = cmps[ci] + 16'(k);
                    cyc();
                    if (k == 0 && mat && tog) exp_pin = ~exp_pin;
                    rreg(2'd3, rv);
                    chk("R4 flag sweep", 16'(rv), 16'((k >= 0) && mat));
                    chk("R4 irq sweep", 16'(irq), 16'((k >= 0) && mat && ie));
                    chk("R6 pin sweep", 16'(pin), 16'(exp_pin));
                    chk("R7 wdog sweep", 16'(wrst), 16'((k == 0) && we));
                end
            end
        end
        wdog_en = 1'b0;

        // R8: stalled counter gives one event
        cnt = 16'h0900; tick = 1'b1; cyc();
        wreg(2'd0, 8'h0C); wreg(2'd1, 8'h42); wreg(2'd2, 8'h00);
        wreg(2'd3, 8'h00);
        cnt = 16'h0042; tick = 1'b0;
        cyc();
        exp_pin = ~exp_pin;
        chk("R8 first toggle", 16'(pin), 16'(exp_pin));
        wreg(2'd3, 8'h00);
        repeat (4) cyc();
        rreg(2'd3, rv); chk("R8 no refire on stall", 16'(rv), 16'h0);
        chk("R8 pin stable on stall", 16'(pin), 16'(exp_pin));
        // re-enable through byte writes while stalled: still no event
        wreg(2'd1, 8'h42); wreg(2'd2, 8'h00); cyc();
        rreg(2'd3, rv); chk("R8 no refire after re-enable", 16'(rv), 16'h0);
        tick = 1'b1; cyc();
        cnt = 16'h0043; cyc();
        cnt = 16'h0042; tick = 1'b0; cyc();
        exp_pin = ~exp_pin;
        chk("R8 fires after counter moved", 16'(pin), 16'(exp_pin));
        rreg(2'd3, rv); chk("R8 flag after counter moved", 16'(rv), 16'h1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule